// File: doc/BRIEF.md
# Three-Phase Carrier Modulator with Selectable Common-Mode Injection

This block drives the six switches of a three-leg active rectifier bridge. A control loop supplies three signed phase references at its own rate. Each new set is held in a pending register when the load strobe is high. The set is moved into the duty registers only at the end of a carrier period. A two-bit mode input, also sampled at the end of each period, selects one of three ways to add a common offset to all three references. The offset changes only the voltage common to the legs. The voltage between any two legs stays the same in every mode.

The carrier is a symmetric up/down counter, so each leg switches symmetrically about the period boundary. Each leg's switch request is turned into a complementary high/low pair, with a fixed dead interval of about 1.1 % of the period in which both switches are off. With the default 84 MHz clock, the period is 1200 cycles (70 kHz) and the dead interval is 13 cycles. The bridge is left fully open, so it conducts as a passive diode rectifier, in three cases: the enable input is low, a fault is latched, or reset is active.

Top module: `zsm_top`

## Requirements
- R1: The carrier repeats every PERIOD clock cycles (default 1200). It counts up from 0 to PERIOD/2-1, holds that value for one more cycle, counts back down to 0, and holds 0 for one more cycle. The last cycle of the down count is the period boundary.
- R2: References are signed REF_W-bit (default 16) fractions of half the bus voltage, where 2^(REF_W-1) is full scale. After adding the offset, the leg value v gives duty = PERIOD/2 + floor(v·(PERIOD/2)/2^(REF_W-1)), saturated to 0..PERIOD. The leg's high request lasts 2·floor(duty/2) cycles of each period.
- R3: Mode code 00 (space-vector) adds an offset of -(max+min)/2 of the three references, using an arithmetic shift.
- R4: Mode code 01 (flat-bottom) adds an offset of -full_scale - min, so the lowest phase sits at duty 0.
- R5: Mode code 10 (discontinuous) clamps one phase to a rail. If max+min >= 0 the offset is full_scale - max, which puts the top phase at full duty. Otherwise the offset is -full_scale - min. Mode code 11 behaves as code 00.
- R6: For the same references, the difference in high-request time between any two legs is the same in all three modes.
- R7: References are captured when ref_load is high. Captured references and the mode take effect only from the period after the next boundary. The current period's output is not changed.
- R8: On every change of a leg's request, both of that leg's switches are off for DEAD cycles (round(PERIOD·DEAD_PER_10K/10000), default 13). The high and low switches of a leg are never on together.
- R9: While en is low, all six gate outputs are 0 in the same cycle. After en rises, a full dead interval passes before any switch turns on.
- R10: A high fault_in turns all outputs off at once and latches the off state. Outputs stay off after fault_in falls, until a fault_clr pulse arrives or reset is asserted.
- R11: During reset all six gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low opens all switches |
| fault_in | input | 1 | Fault request, latched |
| fault_clr | input | 1 | Clears the fault latch when fault_in is low |
| ref_load | input | 1 | Captures the three references |
| ref_a | input | 16 | Phase A reference, signed |
| ref_b | input | 16 | Phase B reference, signed |
| ref_c | input | 16 | Phase C reference, signed |
| mode | input | 2 | Offset strategy: 00 space-vector, 01 flat-bottom, 10 discontinuous, 11 as 00 |
| gate_hi | output | 3 | Upper switch drives, bit 0 = A, bit 2 = C |
| gate_lo | output | 3 | Lower switch drives, bit 0 = A, bit 2 = C |

## Verification
The bench measures the on-time of each leg over whole carrier periods. It does this with all-zero references in every mode, where the three modes give mid duty, full off and full on. It also does it with an unbalanced set, where a wrong offset sign or a wrong rail choice shows up as a shifted leg-to-leg difference. To catch references applied mid-period instead of at the boundary, it loads new values just after a falling edge and times the low pulse that is already running. It counts the both-off gap after a lower switch turns off, which catches a missing or miscounted dead interval. It also checks that a released fault keeps the bridge open until the clear pulse, and that re-enabling does not switch a leg on in the first cycle.

// File: rtl/zsm_pkg.sv
package zsm_pkg;

  typedef enum logic [1:0] {
    ZS_SVM  = 2'b00,
    ZS_FLAT = 2'b01,
    ZS_DISC = 2'b10,
    ZS_ALT  = 2'b11
  } zs_mode_e;

endpackage

// File: rtl/zsm_carrier.sv
module zsm_carrier #(
  parameter int HALF = 600,
  parameter int CW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (up_q) begin
      if (cnt_q == CW'(HALF - 1)) up_d = 1'b0;
      else                        cnt_d = cnt_q + 1'b1;
    end else begin
      if (cnt_q == '0) up_d = 1'b1;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = !up_q && (cnt_q == '0);

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(HALF - 1));
  assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0 && up_q));

endmodule

// File: rtl/zsm_duty.sv
module zsm_duty
  import zsm_pkg::*;
#(
  parameter int REF_W  = 16,
  parameter int PERIOD = 1200,
  parameter int DW     = 11
) (
  input  logic signed [REF_W-1:0] ref_i [3],
  input  zs_mode_e                mode_i,
  output logic        [DW-1:0]    duty_o [3]
);

  localparam int HALF = PERIOD / 2;
  localparam int VW   = REF_W + 2;
  localparam int PW   = VW + DW + 2;
  localparam logic signed [VW-1:0] FS     = VW'(1) <<< (REF_W - 1);
  localparam logic signed [PW-1:0] HALF_S = PW'(HALF);
  localparam logic signed [PW-1:0] PER_S  = PW'(PERIOD);

  logic signed [VW-1:0] r [3];
  logic signed [VW-1:0] v [3];
  logic signed [PW-1:0] sc [3];
  logic signed [VW-1:0] mx, mn, sum, off;

  always_comb begin
    for (int i = 0; i < 3; i++) r[i] = VW'(ref_i[i]);
    mx = r[0];
    mn = r[0];
    for (int i = 1; i < 3; i++) begin
      if (r[i] > mx) mx = r[i];
      if (r[i] < mn) mn = r[i];
    end
    sum = mx + mn;
    case (mode_i)
      ZS_FLAT: off = -FS - mn;
      ZS_DISC: off = (sum >= 0) ? (FS - mx) : (-FS - mn);
      default: off = -(sum >>> 1);
    endcase
    for (int i = 0; i < 3; i++) begin
      v[i]  = r[i] + off;
      sc[i] = ((PW'(v[i]) * HALF_S) >>> (REF_W - 1)) + HALF_S;
      if (sc[i] < 0)          duty_o[i] = '0;
      else if (sc[i] > PER_S) duty_o[i] = DW'(PERIOD);
      else                    duty_o[i] = DW'(sc[i]);
    end
  end

endmodule

// File: rtl/zsm_leg.sv
module zsm_leg #(
  parameter int CW   = 10,
  parameter int DW   = 11,
  parameter int DEAD = 13,
  parameter int DTW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] duty_i,
  output logic          hi_o,
  output logic          lo_o
);

  logic           req_q, req_d, run_q, on;
  logic [DTW-1:0] dt_q, dt_d;

  always_comb begin
    req_d = DW'(cnt_i) < (duty_i >> 1);
    dt_d  = dt_q;
    if (run_i && !run_q)     dt_d = DTW'(DEAD);
    else if (req_d != req_q) dt_d = DTW'(DEAD);
    else if (dt_q != '0)     dt_d = dt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      run_q <= 1'b0;
      dt_q  <= '0;
    end else begin
      req_q <= req_d;
      run_q <= run_i;
      dt_q  <= dt_d;
    end
  end

  assign on   = run_i && run_q && (dt_q == '0);
  assign hi_o = on && req_q;
  assign lo_o = on && !req_q;

  assert_dead_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != $past(req_q)) |-> (!hi_o && !lo_o));
  assert_rise_from_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_o) |-> $past(!lo_o));
  assert_rearm_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (!hi_o && !lo_o));

endmodule

// File: rtl/zsm_top.sv
module zsm_top
  import zsm_pkg::*;
#(
  parameter int REF_W        = 16,
  parameter int PERIOD       = 1200,
  parameter int DEAD_PER_10K = 110
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    fault_in,
  input  logic                    fault_clr,
  input  logic                    ref_load,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic        [1:0]       mode,
  output logic        [2:0]       gate_hi,
  output logic        [2:0]       gate_lo
);

  localparam int HALF = PERIOD / 2;
  localparam int CW   = $clog2(HALF);
  localparam int DW   = $clog2(PERIOD + 1);
  localparam int DEAD = (PERIOD * DEAD_PER_10K + 5000) / 10000;
  localparam int DTW  = $clog2(DEAD + 1);

  logic [1:0]             rs_q;
  logic                   rst_s_n;
  logic signed [REF_W-1:0] pend_q [3];
  logic signed [REF_W-1:0] pend_d [3];
  logic        [DW-1:0]   duty_n [3];
  logic        [DW-1:0]   duty_q [3];
  logic        [CW-1:0]   cnt;
  logic                   wrap, fault_q, fault_d, run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  zsm_carrier #(.HALF(HALF), .CW(CW)) u_car (
    .clk(clk), .rst_n(rst_s_n), .cnt_o(cnt), .wrap_o(wrap)
  );

  zsm_duty #(.REF_W(REF_W), .PERIOD(PERIOD), .DW(DW)) u_duty (
    .ref_i(pend_q), .mode_i(zs_mode_e'(mode)), .duty_o(duty_n)
  );

  always_comb begin
    pend_d = pend_q;
    if (ref_load) begin
      pend_d[0] = ref_a;
      pend_d[1] = ref_b;
      pend_d[2] = ref_c;
    end
    fault_d = fault_in || (fault_q && !fault_clr);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      fault_q <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        pend_q[i] <= '0;
        duty_q[i] <= '0;
      end
    end else begin
      fault_q <= fault_d;
      pend_q  <= pend_d;
      if (wrap) duty_q <= duty_n;
    end
  end

  assign run = en && !fault_in && !fault_q;

  for (genvar g = 0; g < 3; g++) begin : g_leg
    zsm_leg #(.CW(CW), .DW(DW), .DEAD(DEAD), .DTW(DTW)) u_leg (
      .clk(clk), .rst_n(rst_s_n), .run_i(run), .cnt_i(cnt),
      .duty_i(duty_q[g]), .hi_o(gate_hi[g]), .lo_o(gate_lo[g])
    );

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
      !$past(wrap) |-> $stable(duty_q[g]));
    assert_duty_range_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
      duty_q[g] <= DW'(PERIOD));
  end

  assert_off_disabled_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en |-> (gate_hi == '0 && gate_lo == '0));
  assert_fault_latch_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fault_q && !fault_clr) |=> (fault_q && gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/tb_zsm_top.sv
module tb_zsm_top;

  localparam int CLK_PERIOD = 12;
  localparam int PER  = 1200;
  localparam int HALF = PER / 2;
  localparam int DEAD = 13;

  logic clk = 1'b0;
  logic rst_n, en, fault_in, fault_clr, ref_load;
  logic signed [15:0] ref_a, ref_b, ref_c;
  logic [1:0] mode;
  logic [2:0] gate_hi, gate_lo;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zsm_top dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fault_in(fault_in),
    .fault_clr(fault_clr), .ref_load(ref_load), .ref_a(ref_a),
    .ref_b(ref_b), .ref_c(ref_c), .mode(mode),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int duty_of(input int v);
    int d;
    d = HALF + ((v * HALF) >>> 15);
    if (d < 0) d = 0;
    if (d > PER) d = PER;
    return d / 2;
  endfunction

  function automatic void model(input int a, b, c, input int m, output int dh[3]);
    int r[3], mx, mn, off;
    r[0] = a; r[1] = b; r[2] = c;
    mx = a; mn = a;
    for (int i = 1; i < 3; i++) begin
      if (r[i] > mx) mx = r[i];
      if (r[i] < mn) mn = r[i];
    end
    if (m == 1)                       off = -32768 - mn;
    else if (m == 2 && mx + mn >= 0)  off = 32768 - mx;
    else if (m == 2)                  off = -32768 - mn;
    else                              off = -((mx + mn) >>> 1);
    for (int i = 0; i < 3; i++) dh[i] = duty_of(r[i] + off);
  endfunction

  function automatic int exp_hi(input int dh);
    if (dh <= 0) return 0;
    if (dh >= HALF) return PER;
    return 2 * dh - DEAD;
  endfunction

  function automatic int exp_lo(input int dh);
    if (dh <= 0) return PER;
    if (dh >= HALF) return 0;
    return PER - 2 * dh - DEAD;
  endfunction

  function automatic int eff(input int h);
    if (h == 0 || h == PER) return h;
    return h + DEAD;
  endfunction

  task automatic load(input int a, b, c, input int m);
    @(negedge clk);
    ref_a = 16'(a); ref_b = 16'(b); ref_c = 16'(c);
    mode = 2'(m); ref_load = 1'b1;
    @(negedge clk);
    ref_load = 1'b0;
    repeat (3 * PER) @(negedge clk);
  endtask

  task automatic measure(output int h[3], output int l[3]);
    for (int i = 0; i < 3; i++) begin h[i] = 0; l[i] = 0; end
    repeat (PER) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        h[i] += int'(gate_hi[i]);
        l[i] += int'(gate_lo[i]);
      end
    end
  endtask

  task automatic run_case(input int a, b, c, input int m, input string req, output int h[3]);
    int dh[3], l[3];
    load(a, b, c, m);
    model(a, b, c, m, dh);
    measure(h, l);
    for (int i = 0; i < 3; i++) begin
      chk(h[i] == exp_hi(dh[i]), {req, " high time"}, h[i], exp_hi(dh[i]));
      chk(l[i] == exp_lo(dh[i]), {req, " low time"}, l[i], exp_lo(dh[i]));
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(gate_hi == 3'b000 && gate_lo == 3'b000, "R11 off in reset",
        int'({gate_hi, gate_lo}), 0);
  endtask

  task automatic t_zero_modes;
    int h[3];
    run_case(0, 0, 0, 0, "R1 R2 R3 svm zero", h);
    run_case(0, 0, 0, 1, "R4 flat zero", h);
    run_case(0, 0, 0, 2, "R5 disc zero", h);
    run_case(0, 0, 0, 3, "R5 code11 as svm", h);
  endtask

  task automatic t_unbalanced;
    int h[3], d0, d1, d2;
    run_case(16384, -8192, -8192, 0, "R3 svm unbalanced", h);
    d0 = eff(h[0]) - eff(h[1]);
    run_case(16384, -8192, -8192, 1, "R4 flat unbalanced", h);
    d1 = eff(h[0]) - eff(h[1]);
    run_case(16384, -8192, -8192, 2, "R5 disc unbalanced", h);
    d2 = eff(h[0]) - eff(h[1]);
    chk(d0 == 450, "R6 line diff svm", d0, 450);
    chk(d1 == d0, "R6 line diff flat", d1, d0);
    chk(d2 == d0, "R6 line diff disc", d2, d0);
    run_case(-20000, 12000, 3000, 2, "R5 disc negative rail", h);
  endtask

  task automatic t_deadtime;
    int gap;
    bit prev, both;
    load(0, 0, 0, 0);
    prev = 1'b0;
    while (!(prev && !gate_lo[0])) begin
      prev = gate_lo[0];
      @(negedge clk);
    end
    gap = 0;
    both = 1'b0;
    while (!gate_hi[0]) begin
      if (!gate_lo[0]) gap++;
      @(negedge clk);
    end
    chk(gap == DEAD, "R8 dead gap", gap, DEAD);
    repeat (PER) begin
      @(negedge clk);
      if ((gate_hi & gate_lo) != 3'b000) both = 1'b1;
    end
    chk(!both, "R8 no overlap", int'(both), 0);
  endtask

  task automatic t_boundary;
    int low;
    bit prev;
    int h[3], l[3], dh[3];
    load(0, 0, 0, 0);
    prev = 1'b0;
    while (!(prev && !gate_hi[0])) begin
      prev = gate_hi[0];
      @(negedge clk);
    end
    ref_a = 16'sd16384; ref_b = '0; ref_c = '0; ref_load = 1'b1;
    low = 0;
    while (!gate_hi[0]) begin
      low++;
      @(negedge clk);
      ref_load = 1'b0;
    end
    chk(low == PER - 2 * 300 + DEAD, "R7 no mid-period update", low, PER - 600 + DEAD);
    repeat (3 * PER) @(negedge clk);
    model(16384, 0, 0, 0, dh);
    measure(h, l);
    chk(h[0] == exp_hi(dh[0]), "R7 applied after boundary", h[0], exp_hi(dh[0]));
  endtask

  task automatic t_enable;
    load(0, 0, 0, 0);
    en = 1'b0;
    #1;
    chk(gate_hi == 0 && gate_lo == 0, "R9 off at once", int'({gate_hi, gate_lo}), 0);
    repeat (50) @(negedge clk);
    chk(gate_hi == 0 && gate_lo == 0, "R9 off while low", int'({gate_hi, gate_lo}), 0);
    en = 1'b1;
    @(negedge clk);
    chk(gate_hi == 0 && gate_lo == 0, "R9 dead after enable", int'({gate_hi, gate_lo}), 0);
  endtask

  task automatic t_fault;
    int on_cnt, h[3];
    load(0, 0, 0, 0);
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
    on_cnt = 0;
    repeat (PER + 100) begin
      @(negedge clk);
      if (gate_hi != 0 || gate_lo != 0) on_cnt++;
    end
    chk(on_cnt == 0, "R10 latched off", on_cnt, 0);
    fault_clr = 1'b1;
    @(negedge clk);
    fault_clr = 1'b0;
    run_case(0, 0, 0, 0, "R10 resume after clear", h);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; fault_in = 1'b0; fault_clr = 1'b0;
    ref_load = 1'b0; ref_a = '0; ref_b = '0; ref_c = '0; mode = 2'b00;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_zero_modes();
    t_unbalanced();
    t_deadtime();
    t_boundary();
    t_enable();
    t_fault();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule